// File: doc/BRIEF.md
# UART interrupt priority identification unit

This unit decides which interrupt a 16550-style serial port reports to the host, and produces the 8-bit identification value that the host reads to find it. It holds the pending state for three event-driven sources: line errors, transmitter holding register empty and modem status changes. It derives the received-data condition from the receive FIFO fill count, using a selectable trigger level. The character timeout condition arrives as a level from the receive logic. It ranks every enabled condition and encodes the winner. It drives an interrupt request that is active whenever something enabled is pending.

During a host read of the identification register the reported value is frozen. A condition that appears in the middle of the access cannot alter the bits the host is sampling. The transmitter-empty condition is acknowledged when such a read ends, if that read reported it. The other sources clear through reads or writes of their own registers, which reach the unit as one-cycle strobes.

Top module: `uart_int_ident`

## Requirements
- R1: Enabled pending sources are ranked line status > received data / timeout > transmitter empty > modem status. The low nibble reads 0x6, 0x4, 0x2 and 0x0 for these sources, in that order, so bit 0 reads 0 whenever any enabled source is pending.
- R2: With no enabled source pending, the value reads 0x01 when `fifo_en` is 0 and 0xC1 when it is 1. `irq` is always the inverse of bit 0 of `iir_out`.
- R3: Bits 7:6 both equal `fifo_en`, and bits 5:4 always read 0.
- R4: When `fifo_en` is 1 and received data is not pending, a high `rx_idle_tmo` reports low nibble 0xC at the same rank as received data. When `fifo_en` is 0, `rx_idle_tmo` has no effect and bit 3 reads 0. Received data wins over timeout when both are pending.
- R5: Received data is pending when `rx_level` is at or above the trigger. With `fifo_en` set, `trig_sel` = 00/01/10/11 selects a trigger of 1/4/8/14 bytes. With `fifo_en` clear, the trigger is always 1.
- R6: A `line_err` pulse sets the line-status condition. A `rd_line_stat` strobe clears it, and a `line_err` pulse in the same cycle wins.
- R7: A `thr_empty_evt` pulse sets the transmitter-empty condition. It is cleared by `wr_thr`, or on the cycle after `iir_rd` falls if the frozen value had low nibble 0x2. A new event in the same cycle wins.
- R8: A `modem_chg` pulse sets the modem-status condition. A `rd_modem_stat` strobe clears it, and an event in the same cycle wins.
- R9: Enable bits are mapped as follows: `int_en[0]` covers received data and timeout, `int_en[1]` covers transmitter empty, `int_en[2]` covers line status and `int_en[3]` covers modem status. A masked source never affects bits 3:0, but its pending state is kept.
- R10: In the first cycle that `iir_rd` is high, `iir_out` shows the live value. That value is then held unchanged for as long as `iir_rd` stays high.
- R11: Reset (`rst_n` low) clears every held condition and the read tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | receive trigger level select |
| int_en | input | 4 | per-source enables |
| rx_level | input | CNT_W | receive FIFO fill count |
| rx_idle_tmo | input | 1 | character timeout pending |
| line_err | input | 1 | overrun/parity/framing/break event pulse |
| rd_line_stat | input | 1 | line status register read strobe |
| thr_empty_evt | input | 1 | transmit holding register became empty |
| wr_thr | input | 1 | transmit holding register write strobe |
| modem_chg | input | 1 | modem status change pulse |
| rd_modem_stat | input | 1 | modem status register read strobe |
| iir_rd | input | 1 | high for the whole identification read access |
| iir_out | output | 8 | identification value |
| irq | output | 1 | interrupt request, active high |

## Verification
The hardest situation to reach is a read access that spans several cycles while a higher-ranked event arrives inside it. The same read must then end with a transmitter-empty acknowledgement that depends on the frozen value rather than the live one. Directed phases hold `iir_rd` high across a `line_err` pulse and across trigger-level changes. A randomized phase toggles `iir_rd` with irregular lengths while all event pulses fire, so reads end on every kind of frozen value. A behavioural reference model is compared on every clock.

// File: rtl/uart_int_ident.sv
module uart_int_ident #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [3:0]       int_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_idle_tmo,
  input  logic             line_err,
  input  logic             rd_line_stat,
  input  logic             thr_empty_evt,
  input  logic             wr_thr,
  input  logic             modem_chg,
  input  logic             rd_modem_stat,
  input  logic             iir_rd,
  output logic [7:0]       iir_out,
  output logic             irq
);

  logic             ls_q, th_q, ms_q, rd_q;
  logic [7:0]       hold_q;
  logic [CNT_W-1:0] trig;
  logic [3:0]       id;
  logic [7:0]       live;
  logic             rda, tmo, reading, thr_ack;

  always_comb begin
    case (trig_sel)
      2'b00:   trig = CNT_W'(1);
      2'b01:   trig = CNT_W'(4);
      2'b10:   trig = CNT_W'(8);
      default: trig = CNT_W'(14);
    endcase
  end

  assign rda = int_en[0] && (rx_level >= (fifo_en ? trig : CNT_W'(1)));
  assign tmo = int_en[0] && fifo_en && rx_idle_tmo;

  always_comb begin
    if (int_en[2] && ls_q)      id = 4'b0110;
    else if (rda)               id = 4'b0100;
    else if (tmo)               id = 4'b1100;
    else if (int_en[1] && th_q) id = 4'b0010;
    else if (int_en[3] && ms_q) id = 4'b0000;
    else                        id = 4'b0001;
  end

  assign live    = {fifo_en, fifo_en, 2'b00, id};
  assign reading = iir_rd && rd_q;
  assign iir_out = reading ? hold_q : live;
  assign irq     = ~iir_out[0];
  assign thr_ack = !iir_rd && rd_q && (hold_q[3:0] == 4'b0010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q   <= 1'b0;
      th_q   <= 1'b0;
      ms_q   <= 1'b0;
      rd_q   <= 1'b0;
      hold_q <= 8'h01;
    end else begin
      if (line_err)          ls_q <= 1'b1;
      else if (rd_line_stat) ls_q <= 1'b0;
      if (thr_empty_evt)          th_q <= 1'b1;
      else if (wr_thr || thr_ack) th_q <= 1'b0;
      if (modem_chg)          ms_q <= 1'b1;
      else if (rd_modem_stat) ms_q <= 1'b0;
      rd_q <= iir_rd;
      if (iir_rd && !rd_q) hold_q <= live;
    end
  end

  assert_frozen_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && $past(iir_rd) && $past(rst_n)) |-> $stable(iir_out));

  assert_line_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_q && int_en[2] && !iir_rd) |-> (iir_out[3:0] == 4'b0110));

  assert_no_tmo_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !iir_rd) |-> (iir_out[3] == 1'b0 && iir_out[7:6] == 2'b00));

  assert_masked_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == 4'b0000 && !iir_rd) |-> (iir_out[3:0] == 4'b0001 && !irq));

  assert_line_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_line_stat && !line_err) |=> (iir_rd || iir_out[3:0] != 4'b0110));

  assert_thr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !thr_empty_evt) |=> (iir_rd || iir_out[3:0] != 4'b0010));

endmodule

// File: tb/test_uart_int_ident.sv
`timescale 1ns/100ps
module test_uart_int_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 0, rx_idle_tmo = 0, line_err = 0, rd_line_stat = 0;
  logic       thr_empty_evt = 0, wr_thr = 0, modem_chg = 0, rd_modem_stat = 0, iir_rd = 0;
  logic [1:0] trig_sel = 0;
  logic [3:0] int_en = 0;
  logic [4:0] rx_level = 0;
  logic [7:0] iir_out;
  logic       irq;

  int    n_run = 0, n_fail = 0, cycles = 0;
  bit    live_chk = 0, done = 0;
  string cur_req = "R11";

  int       m_ls = 0, m_th = 0, m_ms = 0, m_rdp = 0;
  bit [7:0] m_held = 8'h01;

  uart_int_ident i_uart_int_ident (.*);

  always #2.5 clk = ~clk;

  function automatic bit [7:0] model_live();
    int thr, code;
    thr = !fifo_en ? 1 : (trig_sel == 0 ? 1 : trig_sel == 1 ? 4 : trig_sel == 2 ? 8 : 14);
    if (int_en[2] && m_ls != 0)                 code = 6;
    else if (int_en[0] && int'(rx_level) >= thr) code = 4;
    else if (int_en[0] && fifo_en && rx_idle_tmo) code = 12;
    else if (int_en[1] && m_th != 0)            code = 2;
    else if (int_en[3] && m_ms != 0)            code = 0;
    else                                         code = 1;
    return (fifo_en ? 8'hC0 : 8'h00) | 8'(code);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ls <= 0; m_th <= 0; m_ms <= 0; m_rdp <= 0; m_held <= 8'h01;
    end else begin
      m_ls <= line_err ? 1 : (rd_line_stat ? 0 : m_ls);
      m_ms <= modem_chg ? 1 : (rd_modem_stat ? 0 : m_ms);
      if (thr_empty_evt) m_th <= 1;
      else if (wr_thr || (!iir_rd && m_rdp != 0 && m_held[3:0] == 4'h2)) m_th <= 0;
      m_rdp <= iir_rd ? 1 : 0;
      if (iir_rd && m_rdp == 0) m_held <= model_live();
    end
  end

  always @(negedge clk) begin
    bit [7:0] exp;
    cycles++;
    if (live_chk && !done) begin
      exp = (iir_rd && m_rdp != 0) ? m_held : model_live();
      n_run++;
      if (iir_out !== exp) begin
        n_fail++;
        $display("FAIL %s: iir_out=%02h expected %02h at cycle %0d", cur_req, iir_out, exp, cycles);
      end
      n_run++;
      if (irq !== ~exp[0]) begin
        n_fail++;
        $display("FAIL R2 (%s): irq=%0b expected %0b", cur_req, irq, ~exp[0]);
      end
    end
    if (cycles > 100000 && !done) begin
      n_fail++;
      done = 1;
      $display("FAIL watchdog: run stuck, got cycle %0d expected under 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      line_err = 0; rd_line_stat = 0; thr_empty_evt = 0; wr_thr = 0;
      modem_chg = 0; rd_modem_stat = 0;
    end
  endtask

  initial begin
    step(3);
    live_chk = 1;
    cur_req = "R11";
    step(2);
    rst_n = 1;
    step(2);

    cur_req = "R2";
    int_en = 4'hF; step(2);
    fifo_en = 1; step(2);
    cur_req = "R3"; step(1);

    cur_req = "R8";
    modem_chg = 1; step(2);
    rd_modem_stat = 1; modem_chg = 1; step(2);
    rd_modem_stat = 1; step(2);
    modem_chg = 1; step(1);

    cur_req = "R7";
    thr_empty_evt = 1; step(2);
    wr_thr = 1; step(2);
    thr_empty_evt = 1; wr_thr = 1; step(2);

    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int c = 0; c <= 16; c++) begin rx_level = 5'(c); step(1); end
    end
    fifo_en = 0;
    for (int c = 0; c < 3; c++) begin rx_level = 5'(c); step(1); end

    cur_req = "R4";
    rx_level = 0; rx_idle_tmo = 1; step(2);
    fifo_en = 1; trig_sel = 2'b11; rx_level = 3; step(2);
    rx_level = 14; step(2);
    rx_level = 0; rx_idle_tmo = 0; step(1);

    cur_req = "R6";
    line_err = 1; step(2);
    rd_line_stat = 1; line_err = 1; step(2);
    rd_line_stat = 1; step(2);

    cur_req = "R10";
    iir_rd = 1; step(1);
    line_err = 1; step(1);
    rx_level = 16; step(3);
    iir_rd = 0; step(2);
    rd_line_stat = 1; rx_level = 0; step(2);
    modem_chg = 1; thr_empty_evt = 1; step(1);
    iir_rd = 1; step(3);
    iir_rd = 0; step(2);
    iir_rd = 1; step(2);
    iir_rd = 0; rd_modem_stat = 1; step(2);

    cur_req = "R9";
    line_err = 1; thr_empty_evt = 1; modem_chg = 1; rx_level = 16; step(1);
    for (int e = 0; e < 16; e++) begin int_en = 4'(e); step(2); end
    int_en = 4'hF; rd_line_stat = 1; rd_modem_stat = 1; wr_thr = 1; rx_level = 0; step(2);

    cur_req = "R1";
    for (int k = 0; k < 3000; k++) begin
      int_en = 4'($urandom); fifo_en = 1'($urandom % 4 != 0);
      trig_sel = 2'($urandom); rx_level = 5'($urandom % 17);
      rx_idle_tmo = 1'($urandom % 3 == 0);
      if ($urandom % 3 == 0) iir_rd = ~iir_rd;
      @(posedge clk); #1;
      line_err = 1'($urandom % 6 == 0); rd_line_stat = 1'($urandom % 5 == 0);
      thr_empty_evt = 1'($urandom % 6 == 0); wr_thr = 1'($urandom % 7 == 0);
      modem_chg = 1'($urandom % 6 == 0); rd_modem_stat = 1'($urandom % 5 == 0);
    end
    step(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule